// File: doc/BRIEF.md
# Primary Clock Loss Monitor with Reference Failover

This block watches a primary clock for complete loss, timing it against an always-running reference oscillator. A short counter on the primary clock wraps at regular intervals. Each wrap is carried into the reference domain, where it restarts a much longer watchdog counter. If the watchdog counter ever reaches its end without being restarted, the primary clock is declared lost. This happens when the primary clock has stopped or runs far slower than the reference. The block does not measure frequency drift.

Once a loss is detected, a sticky fail flag rises and the watchdog freezes. The block then overrides the clock-tree controls that software programs. The source select is forced to the reference oscillator, the PLL is forced into bypass and the PLL multiplier is forced to zero. The override holds until software writes a one-cycle clear pulse. The clear drops the flag, returns control to the software settings and restarts both counters. A disable level stops monitoring. Monitoring is on after reset. A copy of the fail flag is synchronized into the register-bus domain for status reads.

Top module: `clk_loss_monitor`

## Requirements
- R1: While and after reset, `clk_fail_o` and `fail_sts_o` are 0 and the three clock-control outputs equal their software inputs.
- R2: A primary clock running at most 60 times slower than the reference never raises `clk_fail_o`. Over a window longer than 8192 reference cycles, this holds both for a fast primary clock and for a primary clock exactly 60 times slower.
- R3: When the primary clock stops, `clk_fail_o` rises within 8192 plus a few synchronizer cycles of the reference clock, and not more than about 40 reference cycles early. It rises only on the edge after the watchdog counter has reached its maximum value.
- R4: A primary clock 70 times slower than the reference raises `clk_fail_o` within about 8192 reference cycles of reset.
- R5: Once `clk_fail_o` is high, it stays high and the watchdog count stays frozen until a clear, even if the primary clock resumes.
- R6: While `clk_fail_o` is high, the outputs are forced as follows, whatever the inputs: `src_sel_o` = 2'b00 (the reference oscillator code), `pll_bypass_o` = 1 and `pll_mult_o` = 0.
- R7: A one-cycle pulse on `clr_i` drops `clk_fail_o` within 10 reference cycles, and the outputs then follow the software inputs again. The clear restarts the watchdog from zero, so with the primary clock still stopped the flag returns only after another full 8192-cycle window. In the same reference cycle, a clear takes priority over a new detection.
- R8: While `mon_dis_i` is 1, no detection occurs and the watchdog is held at zero. After `mon_dis_i` returns to 0, a full window must elapse before a stopped primary clock is flagged.
- R9: `fail_sts_o` follows `clk_fail_o` into the `clk_i` domain within 4 `clk_i` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register-bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pri_clk_i | input | 1 | Monitored primary clock |
| ref_clk_i | input | 1 | Always-on reference clock |
| clr_i | input | 1 | One-cycle clear pulse, `clk_i` domain |
| mon_dis_i | input | 1 | 1 disables detection (level) |
| src_sel_i | input | 2 | Software clock-source select |
| pll_bypass_i | input | 1 | Software PLL bypass |
| pll_mult_i | input | MULT_W | Software PLL multiplier |
| clk_fail_o | output | 1 | Sticky clock-fail flag, reference domain |
| fail_sts_o | output | 1 | Fail flag synchronized to `clk_i` |
| src_sel_o | output | 2 | Effective source select |
| pll_bypass_o | output | 1 | Effective PLL bypass |
| pll_mult_o | output | MULT_W | Effective PLL multiplier |

## Verification
The bench probes the detection window from both sides. A primary clock 60 times slower than the reference must survive, and one 70 times slower must be flagged. A design that compares against the wrong counter end, or loses wrap pulses in the synchronizer, fails one side of that pair. The latency after a stop is bounded from above and from below, which catches a watchdog that is off by a bit or starts at the wrong value. A clear is issued while the primary clock is still dead; a design that skips the counter restart would re-flag at once instead of after a full window. The disable test exposes a watchdog that keeps counting while masked.

// File: rtl/clk_loss_pkg.sv
package clk_loss_pkg;
  typedef enum logic [1:0] {
    SRC_REF  = 2'd0,
    SRC_XTAL = 2'd1,
    SRC_EXT  = 2'd2,
    SRC_AUX  = 2'd3
  } clk_src_e;
  localparam int unsigned SRC_W = 2;
endpackage

// File: rtl/cl_sync.sv
module cl_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= d_i;
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/cl_tgl_rx.sv
// Receives a toggle from another domain and emits a one-cycle pulse per flip.
module cl_tgl_rx #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tgl_i,
  output logic pulse_o
);
  logic sync_s;
  logic last_q;

  cl_sync #(.STAGES(STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (tgl_i),
    .q_o    (sync_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= sync_s;

  assign pulse_o = sync_s ^ last_q;
endmodule

// File: rtl/cl_pri_cnt.sv
// Free-running primary counter; flips tgl_o each time it wraps.
module cl_pri_cnt #(
  parameter int unsigned W = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tgl_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tgl_o <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (&cnt_q) tgl_o <= ~tgl_o;
    end
  end
endmodule

// File: rtl/cl_ref_watch.sv
// Reference-domain watchdog: restarted by primary wraps, flags loss at full count.
module cl_ref_watch #(
  parameter int unsigned W = 13
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         wrap_i,
  input  logic         dis_i,
  output logic         fail_o,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;
  logic         fail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      fail_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      fail_q <= 1'b0;
    end else if (fail_q) begin
      cnt_q  <= cnt_q;
    end else if (dis_i || wrap_i) begin
      cnt_q  <= '0;
    end else if (&cnt_q) begin
      fail_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign fail_o = fail_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/cl_failover.sv
module cl_failover
  import clk_loss_pkg::*;
#(
  parameter int unsigned MULT_W = 7
) (
  input  logic              force_i,
  input  logic [SRC_W-1:0]  src_sel_i,
  input  logic              bypass_i,
  input  logic [MULT_W-1:0] mult_i,
  output logic [SRC_W-1:0]  src_sel_o,
  output logic              bypass_o,
  output logic [MULT_W-1:0] mult_o
);
  always_comb begin
    if (force_i) begin
      src_sel_o = SRC_REF;
      bypass_o  = 1'b1;
      mult_o    = '0;
    end else begin
      src_sel_o = src_sel_i;
      bypass_o  = bypass_i;
      mult_o    = mult_i;
    end
  end
endmodule

// File: rtl/clk_loss_monitor.sv
module clk_loss_monitor
  import clk_loss_pkg::*;
#(
  parameter int unsigned PRI_W       = 7,
  parameter int unsigned REF_W       = 13,
  parameter int unsigned MULT_W      = 7,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pri_clk_i,
  input  logic              ref_clk_i,
  input  logic              clr_i,
  input  logic              mon_dis_i,
  input  logic [SRC_W-1:0]  src_sel_i,
  input  logic              pll_bypass_i,
  input  logic [MULT_W-1:0] pll_mult_i,
  output logic              clk_fail_o,
  output logic              fail_sts_o,
  output logic [SRC_W-1:0]  src_sel_o,
  output logic              pll_bypass_o,
  output logic [MULT_W-1:0] pll_mult_o
);
  logic             clr_tgl_q;
  logic             clr_ref_p;
  logic             clr_pri_p;
  logic             pri_tgl;
  logic             pri_wrap_p;
  logic             dis_ref;
  logic             fail;
  logic [REF_W-1:0] ref_cnt;

  // clear command as a toggle, so either domain can catch it
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    clr_tgl_q <= 1'b0;
    else if (clr_i) clr_tgl_q <= ~clr_tgl_q;

  cl_tgl_rx #(.STAGES(SYNC_STAGES)) u_clr_ref (
    .clk_i(ref_clk_i), .rst_ni(rst_ni), .tgl_i(clr_tgl_q), .pulse_o(clr_ref_p)
  );

  cl_tgl_rx #(.STAGES(SYNC_STAGES)) u_clr_pri (
    .clk_i(pri_clk_i), .rst_ni(rst_ni), .tgl_i(clr_tgl_q), .pulse_o(clr_pri_p)
  );

  cl_pri_cnt #(.W(PRI_W)) u_pri (
    .clk_i(pri_clk_i), .rst_ni(rst_ni), .clr_i(clr_pri_p), .tgl_o(pri_tgl)
  );

  cl_tgl_rx #(.STAGES(SYNC_STAGES)) u_wrap_ref (
    .clk_i(ref_clk_i), .rst_ni(rst_ni), .tgl_i(pri_tgl), .pulse_o(pri_wrap_p)
  );

  cl_sync #(.STAGES(SYNC_STAGES)) u_dis_ref (
    .clk_i(ref_clk_i), .rst_ni(rst_ni), .d_i(mon_dis_i), .q_o(dis_ref)
  );

  cl_ref_watch #(.W(REF_W)) u_watch (
    .clk_i  (ref_clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_ref_p),
    .wrap_i (pri_wrap_p),
    .dis_i  (dis_ref),
    .fail_o (fail),
    .cnt_o  (ref_cnt)
  );

  cl_sync #(.STAGES(SYNC_STAGES)) u_sts (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(fail), .q_o(fail_sts_o)
  );

  cl_failover #(.MULT_W(MULT_W)) u_fo (
    .force_i   (fail),
    .src_sel_i (src_sel_i),
    .bypass_i  (pll_bypass_i),
    .mult_i    (pll_mult_i),
    .src_sel_o (src_sel_o),
    .bypass_o  (pll_bypass_o),
    .mult_o    (pll_mult_o)
  );

  assign clk_fail_o = fail;
endmodule

// File: rtl/clk_loss_monitor_chk.sv
module clk_loss_monitor_chk #(
  parameter int unsigned REF_W  = 13,
  parameter int unsigned MULT_W = 7
) (
  input logic             ref_clk_i,
  input logic             rst_ni,
  input logic             clr_ref_p,
  input logic             dis_ref,
  input logic             fail,
  input logic [REF_W-1:0] ref_cnt,
  input logic [1:0]       src_sel_o,
  input logic             pll_bypass_o,
  input logic [MULT_W-1:0] pll_mult_o
);
  p_rise_at_full_r3: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    $rose(fail) |-> &$past(ref_cnt));

  p_fail_sticky_r5: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    fail && !clr_ref_p |=> fail);

  p_cnt_frozen_r5: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    fail && !clr_ref_p |=> $stable(ref_cnt));

  p_forced_sel_r6: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    fail |-> (src_sel_o == 2'd0) && pll_bypass_o && (pll_mult_o == '0));

  p_clear_wins_r7: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    clr_ref_p |=> !fail && (ref_cnt == '0));

  p_no_detect_dis_r8: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    dis_ref && !fail |=> !fail);
endmodule

bind clk_loss_monitor clk_loss_monitor_chk #(.REF_W(REF_W), .MULT_W(MULT_W)) u_chk (
  .ref_clk_i    (ref_clk_i),
  .rst_ni       (rst_ni),
  .clr_ref_p    (clr_ref_p),
  .dis_ref      (dis_ref),
  .fail         (fail),
  .ref_cnt      (ref_cnt),
  .src_sel_o    (src_sel_o),
  .pll_bypass_o (pll_bypass_o),
  .pll_mult_o   (pll_mult_o)
);

// File: tb/clk_loss_monitor_tb_top.sv
`timescale 1ns/1ps
module clk_loss_monitor_tb_top;
  localparam int MULT_W = 7;
  localparam int WIN    = 8192;

  logic clk = 1'b0;
  logic ref_clk = 1'b0;
  logic pri_clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic mon_dis = 1'b0;
  logic [1:0] src_sel_in = 2'd1;
  logic byp_in = 1'b0;
  logic [MULT_W-1:0] mult_in = 7'd5;
  logic clk_fail, fail_sts, byp_out;
  logic [1:0] src_sel_out;
  logic [MULT_W-1:0] mult_out;

  realtime pri_half = 5.0;
  bit      pri_run  = 1'b0;
  int      checks = 0;
  int      errors = 0;

  always #10 clk = ~clk;
  always #20 ref_clk = ~ref_clk;
  initial forever begin
    #(pri_half);
    if (pri_run) pri_clk = ~pri_clk;
  end

  clk_loss_monitor #(.MULT_W(MULT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pri_clk_i(pri_clk), .ref_clk_i(ref_clk),
    .clr_i(clr), .mon_dis_i(mon_dis), .src_sel_i(src_sel_in),
    .pll_bypass_i(byp_in), .pll_mult_i(mult_in), .clk_fail_o(clk_fail),
    .fail_sts_o(fail_sts), .src_sel_o(src_sel_out), .pll_bypass_o(byp_out),
    .pll_mult_o(mult_out)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic check_rng(input string req, input int got, input int lo, input int hi);
    checks++;
    if (got < lo || got > hi) begin
      errors++;
      $display("FAIL %s got %0d expected %0d..%0d", req, got, lo, hi);
    end
  endtask

  task automatic wait_ref(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic pulse_clr();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
  endtask

  // returns ref cycles until clk_fail seen, -1 if not within max_n
  task automatic wait_fail(input int max_n, output int lat);
    lat = -1;
    for (int i = 1; i <= max_n; i++) begin
      @(negedge ref_clk);
      if (clk_fail) begin
        lat = i;
        break;
      end
    end
  endtask

  task automatic t_reset();
    #55;
    check("R1 fail in reset", clk_fail, 0);
    do_reset();
    @(negedge ref_clk);
    check("R1 fail after reset", clk_fail, 0);
    check("R1 sts after reset", fail_sts, 0);
    check("R1 src_sel", src_sel_out, 1);
    check("R1 bypass", byp_out, 0);
    check("R1 mult", mult_out, 5);
  endtask

  task automatic t_healthy();
    int lat;
    pri_half = 5.0; pri_run = 1'b1;
    do_reset();
    wait_fail(9000, lat);
    check("R2 fast primary no fail", lat, -1);
    pri_half = 1200.0;  // 60x reference period
    do_reset();
    wait_fail(18000, lat);
    check("R2 60x slower no fail", lat, -1);
  endtask

  task automatic t_stop_detect();
    int lat;
    pri_half = 5.0; pri_run = 1'b1;
    do_reset();
    wait_ref(3000);
    pri_run = 1'b0;
    wait_fail(WIN + 100, lat);
    check_rng("R3 stop latency", lat, WIN - 60, WIN + 8);
    repeat (4) @(negedge clk);
    check("R9 status follows", fail_sts, 1);
  endtask

  task automatic t_override();
    src_sel_in = 2'd2; byp_in = 1'b0; mult_in = 7'd9;
    @(negedge ref_clk);
    check("R6 forced src_sel", src_sel_out, 0);
    check("R6 forced bypass", byp_out, 1);
    check("R6 forced mult", mult_out, 0);
  endtask

  task automatic t_clear_stopped();
    int lat;
    pulse_clr();
    wait_ref(10);
    check("R7 clear drops fail", clk_fail, 0);
    check("R7 src follows sw", src_sel_out, 2);
    wait_fail(WIN + 100, lat);
    check_rng("R7 full window after clear", lat + 10, WIN - 40, WIN + 12);
  endtask

  task automatic t_sticky_clear_running();
    pri_half = 5.0; pri_run = 1'b1;
    wait_ref(2000);
    check("R5 fail sticky", clk_fail, 1);
    pulse_clr();
    wait_ref(10);
    check("R7 clear with clock running", clk_fail, 0);
    check("R7 mult follows sw", mult_out, 9);
    check("R7 bypass follows sw", byp_out, 0);
    wait_ref(500);
    check("R7 stays clear", clk_fail, 0);
  endtask

  task automatic t_disable();
    int lat;
    pri_run = 1'b0;
    mon_dis = 1'b1;
    do_reset();
    wait_fail(9000, lat);
    check("R8 disabled no fail", lat, -1);
    @(negedge ref_clk) mon_dis = 1'b0;
    wait_fail(WIN + 100, lat);
    check_rng("R8 window after enable", lat, WIN - 40, WIN + 8);
  endtask

  task automatic t_slow70();
    int lat;
    pri_half = 1400.0; pri_run = 1'b1;  // 70x reference period
    do_reset();
    wait_fail(WIN + 100, lat);
    check_rng("R4 70x slower detected", lat, WIN - 40, WIN + 8);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired got 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_healthy();
    t_stop_detect();
    t_override();
    t_clear_stopped();
    t_sticky_clear_running();
    t_disable();
    t_slow70();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule